// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer controlled through a single 16-bit control register on a simple synchronous bus. Every write must carry the key 0x5A in the upper byte. A write with any other upper byte leaves the register unchanged and raises the reset request. This gives software a way to force a system reset on purpose. A read always returns 0x69 in the upper byte, so writing back a value that was just read always fails the key check and resets the system.

The counter advances on one of two tick sources. Both arrive as single-cycle enable pulses in the system clock domain, and a select bit picks between the two enables. A 2-bit field sets the timeout length. Once the selected number of ticks has been counted, the block pulses its registered reset request for one cycle, clears the counter and returns the control register to its reset value. A hold bit stops counting, and a self-clearing clear bit restarts the count from zero.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the read data is 0x6900 and rst_req is 0. Counting runs on the fast tick with the 32768-tick interval.
- R2: A write (bus_sel=1 and bus_we=1 in the same cycle) with bus_wdata[15:8]=0x5A stores bits [7:4] and [2:0] of the lower byte. The new value is visible on bus_rdata from the next cycle on.
- R3: A write whose upper byte is not 0x5A leaves the lower byte unchanged, and rst_req is 1 in the cycle after that write.
- R4: bus_rdata[15:8] always reads 0x69.
- R5: Bits [1:0] select the timeout in ticks: 00 gives 32768, 01 gives 8192, 10 gives 512 and 11 gives 64.
- R6: Bit 2 selects the tick source: 0 uses fast_tick and 1 uses slow_tick.
- R7: While bit 7 is 1, the counter neither advances nor times out.
- R8: Writing 1 to bit 3 with a valid key zeroes the counter. Bit 3 always reads back 0.
- R9: On the tick that completes the interval, rst_req is 1 for exactly the next cycle. The counter returns to zero and the lower byte returns to 0x00.
- R10: A valid write that changes bits [2:0] zeroes the counter. A valid write that keeps them neither advances nor clears the counter in that cycle.
- R11: Writing back a value just read from bus_rdata raises rst_req in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | Single-cycle enable of the fast tick source |
| slow_tick | input | 1 | Single-cycle enable of the slow tick source |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_wdata | input | 16 | Write data; the upper byte carries the key |
| bus_rdata | output | 16 | Read data: 0x69 tag in the upper byte, control bits in the lower byte |
| rst_req | output | 1 | Registered system reset request |

## Verification
The hardest case to reach from the ports is a valid write that lands partway through an interval without clearing the counter. The timeout then depends on ticks counted before the write and on the one cycle in which the write freezes the count. The stimulus sets the short interval and lets exactly 40 ticks pass. It then rewrites the same interval without the clear bit and measures the remaining ticks to the reset pulse. The bench runs the same sequence with a changed interval, and again with the hold bit set across a long idle stretch. The long interval lengths are measured end to end with a fast tick on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 16;
  localparam int CNT_W    = 16;
  localparam logic [7:0] KEY_WR = 8'h5A;
  localparam logic [7:0] TAG_RD = 8'h69;

  // lower-byte bit positions
  localparam int HOLD_B  = 7;
  localparam int CLR_B   = 3;
  localparam int SRC_B   = 2;

  // log2 of each interval length
  localparam int IVL_LOG2_0 = 15;
  localparam int IVL_LOG2_1 = 13;
  localparam int IVL_LOG2_2 = 9;
  localparam int IVL_LOG2_3 = 6;

  function automatic logic [CNT_W-1:0] ivl_last(input logic [1:0] sel);
    logic [CNT_W:0] len;
    case (sel)
      2'd0:    len = (CNT_W+1)'(1) << IVL_LOG2_0;
      2'd1:    len = (CNT_W+1)'(1) << IVL_LOG2_1;
      2'd2:    len = (CNT_W+1)'(1) << IVL_LOG2_2;
      default: len = (CNT_W+1)'(1) << IVL_LOG2_3;
    endcase
    return CNT_W'(len - 1'b1);
  endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [7:0]        ctrl_o,
  output logic              key_bad_o,
  output logic              wr_ok_o,
  output logic              cnt_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [7:0] ctrl_q;
  logic [7:0] ctrl_new;

  assign wr_ok_o   = wr_en && (wdata[DATA_W-1:8] == KEY_WR);
  assign key_bad_o = wr_en && (wdata[DATA_W-1:8] != KEY_WR);
  assign ctrl_new  = wdata[7:0] & ~(8'(1) << CLR_B);
  assign cnt_clr_o = wr_ok_o && (wdata[CLR_B] || (ctrl_new[2:0] != ctrl_q[2:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= 8'h00;
    else if (wr_ok_o) ctrl_q <= ctrl_new;
    else if (expire)  ctrl_q <= 8'h00;
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {TAG_RD, ctrl_q};

  assert_bad_key_keeps_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_bad_o && !expire) |=> $stable(ctrl_q));
  assert_clear_bit_not_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok_o |=> !ctrl_q[CLR_B]);
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_tick,
  input  logic       slow_tick,
  input  logic [7:0] ctrl,
  input  logic       wr_ok,
  input  logic       cnt_clr,
  output logic       expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             tick;
  logic             run;

  assign tick = ctrl[SRC_B] ? slow_tick : fast_tick;
  assign last = ivl_last(ctrl[1:0]);
  assign run  = tick && !ctrl[HOLD_B] && !wr_ok;
  assign expire_o = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_clr)  cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_within_interval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[HOLD_B] && !wr_ok) |=> $stable(cnt_q));
  assert_plain_write_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !cnt_clr) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic [7:0]       ctrl;
  logic             key_bad;
  logic             wr_ok;
  logic             cnt_clr;
  logic             expire;
  logic [CNT_W-1:0] cnt;

  wdog_ctrl_reg u_reg (
    .clk, .rst_n,
    .wr_en(bus_sel && bus_we), .wdata(bus_wdata), .expire,
    .ctrl_o(ctrl), .key_bad_o(key_bad), .wr_ok_o(wr_ok),
    .cnt_clr_o(cnt_clr), .rdata_o(bus_rdata)
  );

  wdog_tick_counter u_cnt (
    .clk, .rst_n, .fast_tick, .slow_tick,
    .ctrl, .wr_ok, .cnt_clr,
    .expire_o(expire), .cnt_o(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= expire || key_bad;
  end

  assert_bad_key_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> rst_req);
  assert_timeout_reinit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr_ok) |=> (rst_req && ctrl == 8'h00 && cnt == '0));
  assert_req_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(expire || key_bad));
endmodule

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  logic clk = 0, rst_n = 0, fast_tick = 1, slow_tick = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic rst_req;
  int checks = 0, errors = 0, cycles = 0, slow_ph = 0;
  bit  slow_on = 0;

  // reference model state
  int m_cnt = 0;
  logic [7:0] m_ctrl = 0;
  logic m_rst = 0;

  wdog_keyed dut (.*);

  always #5 clk = ~clk;

  function automatic int interval_len(input logic [1:0] s);
    case (s)
      2'b00: return 32768;
      2'b01: return 8192;
      2'b10: return 512;
      default: return 64;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, cycle by cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ctrl = 0; m_rst = 0;
    end else begin
      bit wr, good, tk, fire;
      wr   = bus_sel && bus_we;
      good = wr && bus_wdata[15:8] == 8'h5A;
      tk   = m_ctrl[2] ? slow_tick : fast_tick;
      fire = !good && tk && !m_ctrl[7] && (m_cnt + 1 == interval_len(m_ctrl[1:0]));
      m_rst = fire || (wr && !good);
      if (good) begin
        logic [7:0] nv;
        nv = {bus_wdata[7:4], 1'b0, bus_wdata[2:0]};
        if (bus_wdata[3] || nv[2:0] != m_ctrl[2:0]) m_cnt = 0;
        m_ctrl = nv;
      end else if (fire) begin
        m_cnt = 0; m_ctrl = 0;
      end else if (tk && !m_ctrl[7]) m_cnt++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (slow_on) begin
      slow_ph = (slow_ph + 1) % 4;
      slow_tick <= (slow_ph == 0);
    end else slow_tick <= 0;
    if (rst_n) begin
      chk(bus_rdata == {8'h69, m_ctrl}, "R4/R2 rdata vs model", bus_rdata, {8'h69, m_ctrl});
      chk(rst_req == m_rst, "R9/R3 rst_req vs model", rst_req, m_rst);
    end
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    while (!rst_req && n < 40000) begin @(negedge clk); n++; end
    chk(n == exp, req, n, exp);
    @(negedge clk);
    chk(!rst_req, {req, " one-cycle pulse R9"}, rst_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata == 16'h6900, "R1 reset rdata", bus_rdata, 16'h6900);
    chk(rst_req == 0, "R1 reset rst_req", rst_req, 0);

    // R2: store with key; hold set to stay quiet
    wr(16'h5A96);
    chk(bus_rdata == 16'h6996, "R2 stored value", bus_rdata, 16'h6996);
    // R8: clear bit reads back 0
    wr(16'h5A8B);
    chk(bus_rdata == 16'h6983, "R8 clear bit reads 0", bus_rdata, 16'h6983);
    // R7: hold for many cycles, no timeout
    repeat (200) @(negedge clk);
    chk(!rst_req && bus_rdata[7:0] == 8'h83, "R7 hold blocks timeout", bus_rdata, 16'h6983);
    // R3: wrong key
    wr(16'h1203);
    chk(rst_req == 1, "R3 bad key reset", rst_req, 1);
    chk(bus_rdata == 16'h6983, "R3 reg unchanged", bus_rdata, 16'h6983);
    @(negedge clk);
    // R11: write back what was read
    wr(bus_rdata);
    chk(rst_req == 1, "R11 write-back reset", rst_req, 1);
    chk(bus_rdata[15:8] == 8'h69, "R4 tag", bus_rdata[15:8], 8'h69);

    // R5 interval lengths, fast tick every cycle
    wr(16'h5A0B); measure("R5 interval 11", 64);
    chk(bus_rdata == 16'h6900, "R9 ctrl back to reset", bus_rdata, 16'h6900);
    wr(16'h5A0A); measure("R5 interval 10", 512);
    wr(16'h5A09); measure("R5 interval 01", 8192);
    wr(16'h5A08); measure("R5 interval 00", 32768);

    // R10: same interval rewritten after 40 ticks keeps count
    wr(16'h5A0B);
    repeat (40) @(negedge clk);
    wr(16'h5A03);
    measure("R10 keep count", 24);
    // R10: changed interval restarts count
    wr(16'h5A0B);
    repeat (40) @(negedge clk);
    wr(16'h5A02);
    measure("R10 change clears", 512);

    // R6: slow source, one tick in four cycles
    slow_on = 1;
    fast_tick = 0;
    @(negedge clk);
    wr(16'h5A0F);
    begin
      int n = 0;
      while (!rst_req && n < 2000) begin @(negedge clk); n++; end
      chk(n >= 253 && n <= 259, "R6 slow source timeout", n, 256);
    end
    slow_on = 0;
    fast_tick = 1;
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule